// File: doc/BRIEF.md
# Depth-Cascadable FIFO Controller

This block is a first-in first-out buffer: a dual-port storage array, a write pointer, a read pointer, an occupancy counter and the empty, full and half-full flags. It works on one clock. Writes and reads are one-cycle strobes. A read returns its word on the registered data output in the cycle after the read is accepted.

Two or more identical instances can be chained into one deeper logical FIFO. Each instance passes a write token and a read token to its neighbour through a two-bit chain output, and the links form a ring. Only the instance holding the write token stores a word, and only the instance holding the read token returns one. Each word therefore sits in exactly one instance. A token passes in the same cycle that its holder touches its last location, so a chain keeps accepting a word every cycle with no extra latency.

The `MODE` parameter selects standalone or chained operation, and two pins change meaning with it. In standalone mode `role_rt_i` is a retransmit strobe and `chain_out_o[0]` is the half-full flag. In chained mode `role_rt_i` low marks the master and `chain_out_o` carries the token pulses.

Top module: `cascade_fifo`

## Requirements
- R1: After reset the instance is empty: `empty_o`=1, `full_o`=0, `chain_out_o`=0 and `rdata_o`=0. Both pointers return to location zero, and words stored before reset are lost.
- R2: Words are read back in the order they were written. A write and a read in the same cycle are both accepted when the FIFO is neither empty nor full.
- R3: After DEPTH words without reads, `full_o`=1. A write while full is dropped and changes no pointer, flag or stored word.
- R4: A read while empty is dropped. `rdata_o` keeps its last value, `empty_o` stays 1 and the read pointer does not move.
- R5: In standalone mode `chain_out_o[0]` is 1 exactly while the stored count is greater than DEPTH/2, and `chain_out_o[1]` is 0.
- R6: In standalone mode a cycle with `role_rt_i`=1 resets the read pointer to zero and leaves the write pointer unchanged. Write and read strobes in that cycle are dropped. The count becomes the write pointer (or DEPTH when full), so all written words replay from the first one.
- R7: In chained mode the instance with `role_rt_i`=0 holds both tokens after reset. Instances with `role_rt_i`=1 hold neither and ignore strobes until a token arrives.
- R8: In chained mode, a write accepted into the last location drives `chain_out_o[0]`=1 in that same cycle and gives up the write token. An instance that sees `chain_in_i[0]`=1 holds the write token from the next edge.
- R9: In chained mode, a read accepted from the last location drives `chain_out_o[1]`=1 in that same cycle and hands the read token on in the same way through `chain_in_i[1]`.
- R10: A ring of N instances behaves as one FIFO of N*DEPTH words. It takes strobes on consecutive cycles across token hand-offs and returns the words in the order written.
- R11: `rdata_o` changes only in the cycle after an accepted read. An instance that does not hold the read token drives zero after any read strobe, so the outputs of a ring can be ORed together.
- R12: `empty_o` is asserted only by the read-token holder and `full_o` only by the write-token holder. The ring's flags are the OR of all instances' flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DW | Registered read data |
| role_rt_i | input | 1 | Retransmit (standalone) or slave select (chained, low = master) |
| chain_in_i | input | 2 | Token in: bit 0 write token, bit 1 read token |
| chain_out_o | output | 2 | Token out (chained); bit 0 is half-full when standalone |
| empty_o | output | 1 | Empty flag |
| full_o | output | 1 | Full flag |

## Verification
The assertions run on every cycle. They check that a dropped write or read leaves its pointer where it was and that retransmit clears only the read pointer. They also check that the count never exceeds the depth, that a token leaves only its holder, and that a holder that passes a token no longer has it on the next edge. What only the bench scenarios can show is the data itself. That covers the order in which words come back, the replay after retransmit, the half-full threshold, and a two-instance ring that runs at one word per cycle across both hand-offs with its ORed outputs.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  typedef enum logic {SOLO = 1'b0, CHAIN = 1'b1} mode_e;
  localparam int TOK_WR = 0;
  localparam int TOK_RD = 1;
endpackage

// File: rtl/cfifo_mem.sv
module cfifo_mem #(
  parameter int DW = 9,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cfifo_ptr.sv
module cfifo_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          clr_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  assign wrap_o = adv_i & ~clr_i & (ptr_o == LAST);

  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_o == '0));  // R6
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ptr_o));  // R4
endmodule

// File: rtl/cfifo_token.sv
module cfifo_token (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic pass_i,
  input  logic take_i,
  output logic has_o
);
  logic boot_q, tok_q;

  // first cycle after reset takes the role from the strap
  assign has_o = boot_q ? master_i : tok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      tok_q  <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      tok_q  <= (has_o & ~pass_i) | take_i;
    end
  end

  AST_PASS_FROM_HOLDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |-> has_o);  // R8
  AST_TOKEN_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_i && !take_i) |=> !has_o);  // R9
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter cfifo_pkg::mode_e MODE = cfifo_pkg::SOLO,
  parameter int DW = 9,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic          role_rt_i,
  input  logic [1:0]    chain_in_i,
  output logic [1:0]    chain_out_o,
  output logic          empty_o,
  output logic          full_o
);
  import cfifo_pkg::*;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam bit CH = (MODE == CHAIN);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q, cnt_rt;
  logic [DW-1:0] mem_rd;
  logic          has_w, has_r, wwrap, rwrap, wr_ok, rd_ok;
  logic          full_l, empty_l, rt, master, hf, drove_q;

  assign master  = CH ? ~role_rt_i : 1'b1;
  assign rt      = ~CH & role_rt_i;
  assign full_l  = (cnt_q == CW'(DEPTH));
  assign empty_l = (cnt_q == '0);
  assign wr_ok   = wr_i & has_w & ~full_l & ~rt;
  assign rd_ok   = rd_i & has_r & ~empty_l & ~rt;
  assign hf      = (cnt_q > CW'(DEPTH / 2));
  assign cnt_rt  = (wptr == '0 && full_l) ? CW'(DEPTH) : {1'b0, wptr};

  cfifo_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i, .rst_ni, .adv_i(wr_ok), .clr_i(1'b0), .ptr_o(wptr), .wrap_o(wwrap));
  cfifo_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk_i, .rst_ni, .adv_i(rd_ok), .clr_i(rt), .ptr_o(rptr), .wrap_o(rwrap));

  cfifo_token u_wtok (
    .clk_i, .rst_ni, .master_i(master), .pass_i(CH & wwrap),
    .take_i(CH & chain_in_i[TOK_WR]), .has_o(has_w));
  cfifo_token u_rtok (
    .clk_i, .rst_ni, .master_i(master), .pass_i(CH & rwrap),
    .take_i(CH & chain_in_i[TOK_RD]), .has_o(has_r));

  cfifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i, .we_i(wr_ok), .waddr_i(wptr), .wdata_i,
    .re_i(rd_ok), .raddr_i(rptr), .rdata_o(mem_rd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      drove_q <= 1'b0;
    end else begin
      if (rt) cnt_q <= cnt_rt;
      else    cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
      if (rd_ok)              drove_q <= 1'b1;
      else if (rd_i & ~has_r) drove_q <= 1'b0;
    end
  end

  assign rdata_o = drove_q ? mem_rd : '0;
  assign empty_o = has_r & empty_l;
  assign full_o  = has_w & full_l;

  generate
    if (CH) begin : g_chain
      assign chain_out_o = {rwrap, wwrap};
    end else begin : g_solo
      assign chain_out_o = {1'b0, hf};
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));  // R3
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_l) |=> $stable(wptr));  // R3
  AST_EMPTY_READ_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_l && !rt) |=> $stable(rptr));  // R4
  AST_RETX_KEEPS_WPTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt |=> $stable(wptr));  // R6
endmodule

// File: tb/cascade_fifo_test.sv
module cascade_fifo_test;
  localparam int DW = 9;
  localparam int D  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // standalone
  logic          s_wr = 0, s_rd = 0, s_rt = 0;
  logic [DW-1:0] s_din = '0, s_dout;
  logic [1:0]    s_xo;
  logic          s_em, s_fu;

  cascade_fifo #(.MODE(cfifo_pkg::SOLO), .DW(DW), .DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(s_wr), .wdata_i(s_din), .rd_i(s_rd),
    .rdata_o(s_dout), .role_rt_i(s_rt), .chain_in_i(2'b00), .chain_out_o(s_xo),
    .empty_o(s_em), .full_o(s_fu));

  // two-instance ring
  logic          c_wr = 0, c_rd = 0;
  logic [DW-1:0] c_din = '0, m_dout, sl_dout;
  logic [1:0]    m_xo, sl_xo;
  logic          m_em, m_fu, sl_em, sl_fu;

  cascade_fifo #(.MODE(cfifo_pkg::CHAIN), .DW(DW), .DEPTH(D)) u_mst (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(c_wr), .wdata_i(c_din), .rd_i(c_rd),
    .rdata_o(m_dout), .role_rt_i(1'b0), .chain_in_i(sl_xo), .chain_out_o(m_xo),
    .empty_o(m_em), .full_o(m_fu));
  cascade_fifo #(.MODE(cfifo_pkg::CHAIN), .DW(DW), .DEPTH(D)) u_slv (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(c_wr), .wdata_i(c_din), .rd_i(c_rd),
    .rdata_o(sl_dout), .role_rt_i(1'b1), .chain_in_i(m_xo), .chain_out_o(sl_xo),
    .empty_o(sl_em), .full_o(sl_fu));

  logic [1:0] m_xo_s, sl_xo_s;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic scyc(input logic w, input logic [DW-1:0] d, input logic r, input logic rt);
    s_wr = w; s_din = d; s_rd = r; s_rt = rt;
    @(posedge clk); #1;
    s_wr = 0; s_rd = 0; s_rt = 0;
  endtask

  task automatic ccyc(input logic w, input logic [DW-1:0] d, input logic r);
    c_wr = w; c_din = d; c_rd = r;
    #1 m_xo_s = m_xo; sl_xo_s = sl_xo;
    @(posedge clk); #1;
    c_wr = 0; c_rd = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 empty", s_em, 1); chk("R1 full", s_fu, 0);
    chk("R1 chain_out", s_xo, 0); chk("R1 rdata", s_dout, 0);
  endtask

  task automatic t_order();
    scyc(1, 9'h101, 0, 0); scyc(1, 9'h0A2, 0, 0); scyc(1, 9'h153, 0, 0);
    chk("R2 not empty", s_em, 0);
    scyc(0, 0, 1, 0); chk("R11 rdata after read", s_dout, 9'h101);
    scyc(1, 9'h0C4, 1, 0); chk("R2 simultaneous", s_dout, 9'h0A2);
    scyc(0, 0, 1, 0); chk("R2 order", s_dout, 9'h153);
    scyc(0, 0, 1, 0); chk("R2 last", s_dout, 9'h0C4);
    chk("R2 empty again", s_em, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < D; i++) begin
      scyc(1, DW'(9'h40 + i), 0, 0);
      if (i == D/2 - 1) chk("R5 half-full at D/2", s_xo[0], 0);
      if (i == D/2)     chk("R5 half-full above D/2", s_xo[0], 1);
    end
    chk("R3 full", s_fu, 1); chk("R5 bit1 zero", s_xo[1], 0);
    scyc(1, 9'h1FF, 0, 0); chk("R3 full kept", s_fu, 1);
    for (int i = 0; i < D; i++) begin
      scyc(0, 0, 1, 0);
      chk("R3 data survives overflow", s_dout, DW'(9'h40 + i));
    end
    chk("R3 empty after drain", s_em, 1); chk("R3 not full", s_fu, 0);
  endtask

  task automatic t_empty();
    scyc(0, 0, 1, 0);
    chk("R4 rdata held", s_dout, 9'h47); chk("R4 still empty", s_em, 1);
    scyc(1, 9'h0E5, 0, 0); scyc(0, 0, 1, 0);
    chk("R4 pointer undisturbed", s_dout, 9'h0E5);
  endtask

  task automatic t_retx();
    do_reset();
    scyc(1, 9'h011, 0, 0); scyc(1, 9'h022, 0, 0); scyc(1, 9'h033, 0, 0);
    scyc(0, 0, 1, 0); scyc(0, 0, 1, 0);
    scyc(1, 9'h1AA, 1, 1);
    chk("R6 read dropped", s_dout, 9'h022); chk("R6 not empty", s_em, 0);
    scyc(0, 0, 1, 0); chk("R6 replay 0", s_dout, 9'h011);
    scyc(0, 0, 1, 0); chk("R6 replay 1", s_dout, 9'h022);
    scyc(0, 0, 1, 0); chk("R6 replay 2", s_dout, 9'h033);
    chk("R6 write dropped", s_em, 1);
  endtask

  task automatic t_chain();
    do_reset();
    chk("R7 master empty", m_em, 1); chk("R7 slave no flags", {sl_em, sl_fu}, 0);
    for (int i = 0; i < 2*D; i++) begin
      ccyc(1, DW'(9'h100 + i), 0);
      if (i == D-1)   chk("R8 master passes write token", m_xo_s[0], 1);
      if (i == D-2)   chk("R8 no early pass", m_xo_s[0], 0);
      if (i == 2*D-1) chk("R8 slave passes write token", sl_xo_s[0], 1);
      if (i == 0)     chk("R12 slave empty_o low", sl_em, 0);
    end
    chk("R10 ring full", m_fu | sl_fu, 1); chk("R12 slave full_o low", sl_fu, 0);
    ccyc(1, 9'h0FF, 0);
    for (int i = 0; i < 2*D; i++) begin
      ccyc(0, 0, 1);
      chk("R10 ring order", m_dout | sl_dout, DW'(9'h100 + i));
      if (i == D-1) chk("R9 master passes read token", m_xo_s[1], 1);
      if (i == D)   chk("R11 non-holder drives zero", m_dout, 0);
    end
    chk("R10 ring empty", m_em | sl_em, 1); chk("R12 slave empty_o low", sl_em, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_full();
    t_empty();
    t_retx();
    t_chain();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule